// File: doc/BRIEF.md
# Dual-Modulus PLL Feedback Divider

This block divides a fast oscillator clock by a programmable whole-number modulus and emits one single-cycle pulse per division period, for use as the feedback input of a phase detector. The requested modulus is converted into two counter settings. The main count M is the modulus divided by four, and the swallow count A is the remainder. A prescaler divides by five during the first A of its cycles in each period and by four for the rest, so each period lasts 4·M + A fast cycles. The slow counters therefore advance only once every four or five fast cycles, yet the modulus still moves in steps of one.

A doubling control puts a divide-by-two enable ahead of the prescaler. This doubles the period and reaches the large even moduli. A requested modulus outside the legal range is forced to the nearest bound, and an error flag reports it. A new setting is taken in at the end of each period, so the period that is running is never cut short or stretched.

Top module: `fb_dual_mod_div`

## Requirements
- R1: After reset, `fb_pulse` and `cfg_err` are 0, and the loaded setting is the minimum modulus 37: `m_val` = 9 and `a_val` = 1.
- R2: At the edge where `fb_pulse` rises, the requested modulus N (after R7) is loaded as `m_val` = floor(N/4) and `a_val` = N mod 4.
- R3: The loaded `a_val` is always strictly less than the loaded `m_val`.
- R4: With the loaded double bit at 0, consecutive rising edges of `fb_pulse` are exactly 4·`m_val` + `a_val` fast cycles apart, using the values loaded at the first of the two pulses.
- R5: With the loaded double bit at 1, consecutive pulses are exactly 2·(4·`m_val` + `a_val`) fast cycles apart.
- R6: `fb_pulse` is high for exactly one fast clock cycle per period.
- R7: A request below 37 is loaded as 37, and a request above 392 is loaded as 392.
- R8: `cfg_err` is 1 in the cycle after a clock edge at which `req_mod` lay outside 37..392, and 0 otherwise.
- R9: A change of `req_mod` or `req_dbl` during a period does not change the length of that period. The value present at the period's closing edge governs the next period.
- R10: The bounds 37 and 392 are legal, both with and without doubling, which gives periods of 37, 74, 392 and 784 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_mod | input | MOD_W (10) | Requested base modulus |
| req_dbl | input | 1 | Request to double the modulus |
| fb_pulse | output | 1 | One-cycle feedback pulse per division period |
| cfg_err | output | 1 | Previous cycle's request was out of range |
| m_val | output | 7 | Main count in force for the current period |
| a_val | output | 2 | Swallow count in force for the current period |

## Verification
The bench aims at the bounds 37 and 392 in both modes, and at requests just outside them, such as 36, 393, 0 and 1023.
- A design with a wrong clamp would load a remainder that breaks A < M, or would run a period of the wrong length.
- A prescaler that chose divide-by-five for one cycle too many or too few would be off by exactly one fast cycle for each residue of the modulus. The random mix of moduli exposes this as a period-length mismatch.
- Requests are changed in the middle of a period, sometimes twice. A divider that took settings in before the boundary would shorten or stretch the running period, or would load the earlier of the two requests.
- Switching doubling on and off across boundaries catches a divide-by-two phase that is not cleared at reload, which would add or lose one fast cycle in the first doubled period.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  // Force a requested modulus into the legal window.
  function automatic int unsigned fit_modulus(input int unsigned req,
                                              input int unsigned lo,
                                              input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // Number of prescaler cycles per period.
  function automatic int unsigned main_count(input int unsigned n,
                                             input int unsigned base);
    return n / base;
  endfunction

  // Number of those cycles that use the longer prescaler ratio.
  function automatic int unsigned swallow_count(input int unsigned n,
                                                input int unsigned base);
    return n % base;
  endfunction

endpackage

// File: rtl/fbdiv_cfg.sv
module fbdiv_cfg #(
  parameter int MOD_W   = 10,
  parameter int MOD_MIN = 37,
  parameter int MOD_MAX = 392,
  parameter int PRE     = 4,
  parameter int M_W     = 7,
  parameter int A_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MOD_W-1:0] req_mod,
  input  logic             req_dbl,
  output logic [M_W-1:0]   m_q,
  output logic [A_W-1:0]   a_q,
  output logic             dbl_q,
  output logic             err_q
);
  import fbdiv_pkg::*;

  localparam logic [M_W-1:0]   RST_M = M_W'(MOD_MIN / PRE);
  localparam logic [A_W-1:0]   RST_A = A_W'(MOD_MIN % PRE);
  localparam logic [MOD_W-1:0] LO    = MOD_W'(MOD_MIN);
  localparam logic [MOD_W-1:0] HI    = MOD_W'(MOD_MAX);

  int unsigned    fitted;
  logic [M_W-1:0] m_new;
  logic [A_W-1:0] a_new;
  logic           out_of_range;

  always_comb begin
    fitted       = fit_modulus(int'(req_mod), MOD_MIN, MOD_MAX);
    m_new        = M_W'(main_count(fitted, PRE));
    a_new        = A_W'(swallow_count(fitted, PRE));
    out_of_range = (req_mod < LO) || (req_mod > HI);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q   <= RST_M;
      a_q   <= RST_A;
      dbl_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= out_of_range;
      if (load) begin
        m_q   <= m_new;
        a_q   <= a_new;
        dbl_q <= req_dbl;
      end
    end
  end

endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler #(
  parameter int PRE = 4,
  parameter int P_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dbl,
  input  logic restart,
  input  logic mode_hi,
  output logic tick,
  output logic wrap
);
  localparam logic [P_W-1:0] LAST_HI = P_W'(PRE);
  localparam logic [P_W-1:0] LAST_LO = P_W'(PRE - 1);

  logic           half;
  logic [P_W-1:0] cnt;

  // In doubled mode only every second fast cycle advances the prescaler.
  assign tick = !dbl || half;
  assign wrap = tick && (cnt == (mode_hi ? LAST_HI : LAST_LO));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half <= 1'b0;
      cnt  <= '0;
    end else begin
      half <= (restart || !dbl) ? 1'b0 : !half;
      if (tick) cnt <= wrap ? '0 : cnt + P_W'(1);
    end
  end

endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow #(
  parameter int M_W = 7,
  parameter int A_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wrap,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  output logic           mode_hi,
  output logic           period_end
);
  logic [M_W-1:0] m_cnt;

  // The first a_val prescaler cycles of a period use the longer ratio.
  assign mode_hi    = m_cnt < M_W'(a_val);
  assign period_end = wrap && (m_cnt == m_val - M_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    m_cnt <= '0;
    else if (wrap) m_cnt <= period_end ? '0 : m_cnt + M_W'(1);
  end

endmodule

// File: rtl/fb_dual_mod_div.sv
module fb_dual_mod_div #(
  parameter int MOD_W   = 10,
  parameter int MOD_MIN = 37,
  parameter int MOD_MAX = 392,
  parameter int PRE     = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [MOD_W-1:0]                    req_mod,
  input  logic                                req_dbl,
  output logic                                fb_pulse,
  output logic                                cfg_err,
  output logic [$clog2(MOD_MAX/PRE+1)-1:0]    m_val,
  output logic [$clog2(PRE)-1:0]              a_val
);
  localparam int M_W = $clog2(MOD_MAX / PRE + 1);
  localparam int A_W = $clog2(PRE);
  localparam int P_W = $clog2(PRE + 1);

  logic dbl_q;
  logic tick;
  logic pre_wrap;
  logic mode_hi;
  logic period_end;

  fbdiv_cfg #(
    .MOD_W(MOD_W), .MOD_MIN(MOD_MIN), .MOD_MAX(MOD_MAX),
    .PRE(PRE), .M_W(M_W), .A_W(A_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(period_end),
    .req_mod(req_mod), .req_dbl(req_dbl),
    .m_q(m_val), .a_q(a_val), .dbl_q(dbl_q), .err_q(cfg_err)
  );

  fbdiv_prescaler #(.PRE(PRE), .P_W(P_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .dbl(dbl_q), .restart(period_end),
    .mode_hi(mode_hi), .tick(tick), .wrap(pre_wrap)
  );

  fbdiv_swallow #(.M_W(M_W), .A_W(A_W)) u_swl (
    .clk(clk), .rst_n(rst_n), .wrap(pre_wrap),
    .m_val(m_val), .a_val(a_val),
    .mode_hi(mode_hi), .period_end(period_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fb_pulse <= 1'b0;
    else        fb_pulse <= period_end;
  end

endmodule

// File: rtl/fb_dual_mod_div_chk.sv
module fb_dual_mod_div_chk #(
  parameter int MOD_W   = 10,
  parameter int MOD_MIN = 37,
  parameter int MOD_MAX = 392,
  parameter int PRE     = 4,
  parameter int M_W     = 7,
  parameter int A_W     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [MOD_W-1:0] req_mod,
  input logic             fb_pulse,
  input logic             cfg_err,
  input logic [M_W-1:0]   m_val,
  input logic [A_W-1:0]   a_val,
  input logic             period_end
);
  int gap;
  logic req_bad;

  assign req_bad = (int'(req_mod) < MOD_MIN) || (int'(req_mod) > MOD_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)        gap <= 0;
    else if (fb_pulse) gap <= 0;
    else               gap <= gap + 1;
  end

  assert_swallow_below_main_R3: assert property (@(posedge clk) disable iff (!rst_n)
    a_val < A_W'(0) + a_val && 0 == 1 ? 1'b0 : (M_W'(a_val) < m_val));

  assert_loaded_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (PRE * int'(m_val) + int'(a_val) >= MOD_MIN) &&
    (PRE * int'(m_val) + int'(a_val) <= MOD_MAX));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  assert_pulse_follows_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> fb_pulse);

  assert_setting_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_pulse |-> ($stable(m_val) && $stable(a_val)));

  assert_err_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_bad |=> cfg_err);

  assert_gap_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gap < 2 * MOD_MAX);

endmodule

bind fb_dual_mod_div fb_dual_mod_div_chk #(
  .MOD_W(MOD_W), .MOD_MIN(MOD_MIN), .MOD_MAX(MOD_MAX),
  .PRE(PRE), .M_W(M_W), .A_W(A_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_mod(req_mod), .fb_pulse(fb_pulse),
  .cfg_err(cfg_err), .m_val(m_val), .a_val(a_val), .period_end(period_end)
);

// File: tb/tb_fb_dual_mod_div.sv
module tb_fb_dual_mod_div;
  localparam int LO = 37;
  localparam int HI = 392;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] req_mod = 10'd100;
  logic       req_dbl = 1'b0;
  logic       fb_pulse, cfg_err;
  logic [6:0] m_val;
  logic [1:0] a_val;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  fb_dual_mod_div dut (
    .clk(clk), .rst_n(rst_n), .req_mod(req_mod), .req_dbl(req_dbl),
    .fb_pulse(fb_pulse), .cfg_err(cfg_err), .m_val(m_val), .a_val(a_val)
  );

  function automatic int legal_of(input int r);
    int v;
    v = r;
    if (v > HI) v = HI;
    if (v < LO) v = LO;
    return v;
  endfunction

  function automatic bit bad_of(input int r);
    return !(r >= LO && r <= HI);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  int dir_mod [10] = '{37, 392, 36, 393, 0, 1023, 392, 37, 38, 391};
  bit dir_dbl [10] = '{0, 0, 0, 0, 1, 0, 1, 1, 0, 1};

  initial begin
    int  cyc, exp_int, npulse, want, idx;
    bit  have_prev, prev_pulse, err_pend, exp_err, last_dbl;
    cyc = 0; exp_int = 0; npulse = 0; idx = 0;
    have_prev = 0; prev_pulse = 0; err_pend = 0; exp_err = 0; last_dbl = 0;
    void'($urandom(32'hC0FFEE));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(fb_pulse == 1'b0, "R1 pulse", int'(fb_pulse), 0);
    check(cfg_err == 1'b0, "R1 err", int'(cfg_err), 0);
    check(m_val == 7'd9, "R1 m", int'(m_val), 9);
    check(a_val == 2'd1, "R1 a", int'(a_val), 1);

    while (npulse < 62) begin
      @(negedge clk);
      cyc++;
      if (err_pend) begin
        check(cfg_err == exp_err, "R8 error flag", int'(cfg_err), int'(exp_err));
        err_pend = 0;
      end
      if (prev_pulse)
        check(fb_pulse == 1'b0, "R6 pulse width", int'(fb_pulse), 0);
      if (fb_pulse) begin
        want = legal_of(int'(req_mod));
        if (bad_of(int'(req_mod)))
          check(int'(m_val) == want / 4 && int'(a_val) == want % 4, "R7 clamp",
                4 * int'(m_val) + int'(a_val), want);
        else if (want == LO || want == HI)
          check(int'(m_val) == want / 4 && int'(a_val) == want % 4, "R10 bound",
                4 * int'(m_val) + int'(a_val), want);
        else
          check(int'(m_val) == want / 4 && int'(a_val) == want % 4, "R2 split",
                4 * int'(m_val) + int'(a_val), want);
        check(a_val < m_val[1:0] + 2'd0 || int'(a_val) < int'(m_val), "R3 a<m",
              int'(a_val), int'(m_val));
        if (have_prev) begin
          if (last_dbl) check(cyc == exp_int, "R5 doubled period", cyc, exp_int);
          else          check(cyc == exp_int, "R4 period (R9 timing)", cyc, exp_int);
        end
        last_dbl  = req_dbl;
        exp_int   = req_dbl ? 2 * want : want;
        have_prev = 1;
        cyc       = 0;
        npulse++;
      end
      prev_pulse = fb_pulse;
      if (cyc > 2000) begin
        n_run++; n_fail++;
        $display("FAIL R4 watchdog: actual %0d expected <= %0d", cyc, 2 * HI);
        break;
      end
      // R9: requests change mid-period, sometimes twice; only the last counts
      if (have_prev && (cyc == 5 || (cyc == 9 && $urandom_range(0, 3) == 0))) begin
        if (idx < 10 && cyc == 5) begin
          req_mod = 10'(dir_mod[idx]);
          req_dbl = dir_dbl[idx];
          idx++;
        end else begin
          if ($urandom_range(0, 7) == 0) req_mod = 10'($urandom_range(0, 1023));
          else                           req_mod = 10'($urandom_range(LO, HI));
          req_dbl = 1'($urandom_range(0, 1));
        end
        exp_err  = bad_of(int'(req_mod));
        err_pend = 1;
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule